// File: doc/BRIEF.md
# Column Partial-Sum Adder Unit

This unit sits under one column of multiplier processing elements and folds that column's product lanes into running partial sums. On an accumulate command it reduces the incoming product lanes to a single value, optionally adds a bias word, and merges the result into a local cache entry chosen by an output-row address. It then either replaces the entry or adds to it, with saturation at the signed accumulator limits. Partial sums therefore stay inside the unit across cycles and weight blocks, and do not travel back to a global buffer.

A mode input selects the source pattern. On the dense path every product lane contributes. On the sparse path only the lanes flagged in a lane mask contribute. When a row is finished, a drain command reads its entry. The unit can pass the value through a rectified-linear stage, and it presents the value with a valid flag one cycle after the request.

Top module: `col_psum_adder`

## Requirements
- R1: After reset `resValid` is 0, `resData` is 0 and every cache entry reads back as 0.
- R2: An accumulate (`accReq`=1, `drainReq`=0) with `clearFirst`=1 writes the new contribution into entry `rowAddr`, and the previous contents are discarded.
- R3: An accumulate with `clearFirst`=0 adds the new contribution to the existing contents of entry `rowAddr`.
- R4: With `denseEn`=1 the contribution includes every product lane, whatever `laneMask` holds. Lane i is the signed field `prodIn[i*PROD_W +: PROD_W]`.
- R5: With `denseEn`=0 only lane i whose `laneMask[i]` is 1 is summed. With a zero mask the lanes contribute nothing.
- R6: With `biasEn`=1 the signed word `biasIn` is added once to the contribution of that accumulate. With `biasEn`=0 it is ignored.
- R7: A drain (`drainReq`=1) raises `resValid` for exactly the following cycle and shows entry `rowAddr` on `resData` then. Without a drain, `resValid` stays 0.
- R8: With `reluEn`=1 during a drain, a negative entry is shown as 0 and a non-negative entry unchanged. With `reluEn`=0 the entry is shown as stored.
- R9: When `drainReq` and `accReq` are both 1 the drain wins. The accumulate is dropped, and the addressed entry keeps the value that is output.
- R10: The stored result saturates to 2^(ACC_W-1)-1 or -2^(ACC_W-1) instead of wrapping, both on load and on add.
- R11: An accumulate changes only entry `rowAddr`. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| accReq | input | 1 | Accumulate command for this cycle |
| clearFirst | input | 1 | Load instead of add (first block of a row) |
| biasEn | input | 1 | Add `biasIn` to this accumulate |
| biasIn | input | ACC_W | Signed bias word |
| denseEn | input | 1 | 1 = dense path (all lanes), 0 = sparse path (masked lanes) |
| laneMask | input | LANES | Per-lane valid flags used on the sparse path |
| prodIn | input | LANES*PROD_W | Packed signed product lanes from the column |
| rowAddr | input | ADDR_W | Cache entry (output row) for accumulate or drain |
| drainReq | input | 1 | Read the addressed entry out |
| reluEn | input | 1 | Apply rectified-linear clamp on the drained value |
| resValid | output | 1 | Result valid, one cycle after a drain |
| resData | output | ACC_W | Drained, optionally clamped, result |

## Verification
The bench builds the unit with LANES=4, PROD_W=16, ACC_W=32 and DEPTH=8. Four lanes keep every mask pattern small enough to write by hand, and the full 32-bit accumulator is kept so that both saturation limits are real. A bias preload near either limit reaches those limits in one or two accumulates. With eight entries the bench can fill every row and confirm that writes to one row leave all the others untouched.

// File: rtl/col_psum_pkg.sv
package col_psum_pkg;

  // Strobes passed from the command decoder to the datapath
  typedef struct packed {
    logic wrEn;     // write the addressed cache entry
    logic fresh;    // ignore old contents (load)
    logic addBias;  // include the bias word
    logic sparse;   // gate lanes with the lane mask
    logic rdEn;     // drain the addressed entry
    logic relu;     // clamp negatives on drain
  } psum_strobe_t;

endpackage

// File: rtl/psum_lane_reduce.sv
module psum_lane_reduce #(
  parameter int LANES  = 16,
  parameter int PROD_W = 16,
  parameter int SUM_W  = 38
) (
  input  logic [LANES*PROD_W-1:0] prodIn,
  input  logic [LANES-1:0]        laneMask,
  input  logic                    sparse,
  output logic signed [SUM_W-1:0] laneSum
);

  logic signed [SUM_W-1:0] gated [LANES];

  // One gate per lane; a lane drops out only on the sparse path
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PROD_W-1:0] raw;
    logic              keep;
    assign raw       = prodIn[g*PROD_W +: PROD_W];
    assign keep      = sparse ? laneMask[g] : 1'b1;
    assign gated[g]  = keep ? {{(SUM_W-PROD_W){raw[PROD_W-1]}}, raw} : '0;
  end

  always_comb begin
    laneSum = '0;
    for (int i = 0; i < LANES; i++) begin
      laneSum = laneSum + gated[i];
    end
  end

endmodule

// File: rtl/psum_ctrl.sv
module psum_ctrl
  import col_psum_pkg::*;
(
  input  logic         accReq,
  input  logic         drainReq,
  input  logic         clearFirst,
  input  logic         biasEn,
  input  logic         denseEn,
  input  logic         reluEn,
  output psum_strobe_t strb
);

  // A drain claims the cycle; an accumulate issued with it is dropped
  always_comb begin
    strb         = '0;
    strb.rdEn    = drainReq;
    strb.relu    = drainReq & reluEn;
    strb.wrEn    = accReq & ~drainReq;
    strb.fresh   = clearFirst;
    strb.addBias = biasEn;
    strb.sparse  = ~denseEn;
  end

endmodule

// File: rtl/psum_datapath.sv
module psum_datapath
  import col_psum_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int PROD_W = 16,
  parameter int ACC_W  = 32,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  psum_strobe_t            strb,
  input  logic [ADDR_W-1:0]       rowAddr,
  input  logic [LANES*PROD_W-1:0] prodIn,
  input  logic [LANES-1:0]        laneMask,
  input  logic [ACC_W-1:0]        biasIn,
  output logic                    resValid,
  output logic [ACC_W-1:0]        resData
);

  localparam int SUM_W = ACC_W + $clog2(LANES) + 2;
  localparam logic signed [SUM_W-1:0] MAX_W =
    {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] MIN_W =
    {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0]        cacheMem [DEPTH];
  logic [ACC_W-1:0]        rdWord;
  logic signed [SUM_W-1:0] laneSum;
  logic signed [SUM_W-1:0] baseTerm;
  logic signed [SUM_W-1:0] biasTerm;
  logic signed [SUM_W-1:0] total;
  logic [ACC_W-1:0]        satVal;

  psum_lane_reduce #(
    .LANES (LANES),
    .PROD_W(PROD_W),
    .SUM_W (SUM_W)
  ) u_reduce (
    .prodIn  (prodIn),
    .laneMask(laneMask),
    .sparse  (strb.sparse),
    .laneSum (laneSum)
  );

  assign rdWord = cacheMem[rowAddr];

  always_comb begin
    baseTerm = strb.fresh ? '0 : {{(SUM_W-ACC_W){rdWord[ACC_W-1]}}, rdWord};
    biasTerm = strb.addBias ? {{(SUM_W-ACC_W){biasIn[ACC_W-1]}}, biasIn} : '0;
    total    = baseTerm + laneSum + biasTerm;
    if (total > MAX_W) begin
      satVal = {1'b0, {(ACC_W-1){1'b1}}};
    end else if (total < MIN_W) begin
      satVal = {1'b1, {(ACC_W-1){1'b0}}};
    end else begin
      satVal = total[ACC_W-1:0];
    end
  end

  // Local partial-sum cache
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cacheMem[i] <= '0;
    end else if (strb.wrEn) begin
      cacheMem[rowAddr] <= satVal;
    end
  end

  // Readout stage with optional rectified-linear clamp
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resData  <= '0;
    end else begin
      resValid <= strb.rdEn;
      if (strb.rdEn) begin
        resData <= (strb.relu && rdWord[ACC_W-1]) ? '0 : rdWord;
      end
    end
  end

  // Assertion support: address seen in the previous cycle
  logic [ADDR_W-1:0] chkAddr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chkAddr <= '0;
    else       chkAddr <= rowAddr;
  end

  // R7: valid follows a drain by one cycle
  a_r7_valid_after_drain: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> resValid);

  // R7: no valid without a drain
  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> !resValid);

  // R8: clamped output is never negative
  a_r8_relu_nonneg: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.relu) |=> !resData[ACC_W-1]);

  // R9: a drain leaves the addressed entry untouched
  a_r9_drain_keeps_entry: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> (cacheMem[chkAddr] == $past(rdWord)));

  // R10: adding non-negative terms to a non-negative entry never wraps negative
  a_r10_no_wrap_up: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !strb.fresh && !rdWord[ACC_W-1] && !laneSum[SUM_W-1] &&
     (!strb.addBias || !biasIn[ACC_W-1]))
    |=> !cacheMem[chkAddr][ACC_W-1]);

endmodule

// File: rtl/col_psum_adder.sv
module col_psum_adder
  import col_psum_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int PROD_W = 16,
  parameter int ACC_W  = 32,
  parameter int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    accReq,
  input  logic                    clearFirst,
  input  logic                    biasEn,
  input  logic [ACC_W-1:0]        biasIn,
  input  logic                    denseEn,
  input  logic [LANES-1:0]        laneMask,
  input  logic [LANES*PROD_W-1:0] prodIn,
  input  logic [ADDR_W-1:0]       rowAddr,
  input  logic                    drainReq,
  input  logic                    reluEn,
  output logic                    resValid,
  output logic [ACC_W-1:0]        resData
);

  psum_strobe_t strb;

  psum_ctrl u_ctrl (
    .accReq    (accReq),
    .drainReq  (drainReq),
    .clearFirst(clearFirst),
    .biasEn    (biasEn),
    .denseEn   (denseEn),
    .reluEn    (reluEn),
    .strb      (strb)
  );

  psum_datapath #(
    .LANES (LANES),
    .PROD_W(PROD_W),
    .ACC_W (ACC_W),
    .DEPTH (DEPTH)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rowAddr (rowAddr),
    .prodIn  (prodIn),
    .laneMask(laneMask),
    .biasIn  (biasIn),
    .resValid(resValid),
    .resData (resData)
  );

endmodule

// File: tb/col_psum_adder_bench.sv
module col_psum_adder_bench;

  localparam int LANES  = 4;
  localparam int PROD_W = 16;
  localparam int ACC_W  = 32;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam longint MAXV = 64'sd2147483647;
  localparam longint MINV = -64'sd2147483648;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    accReq = 1'b0;
  logic                    clearFirst = 1'b0;
  logic                    biasEn = 1'b0;
  logic [ACC_W-1:0]        biasIn = '0;
  logic                    denseEn = 1'b1;
  logic [LANES-1:0]        laneMask = '0;
  logic [LANES*PROD_W-1:0] prodIn = '0;
  logic [ADDR_W-1:0]       rowAddr = '0;
  logic                    drainReq = 1'b0;
  logic                    reluEn = 1'b0;
  logic                    resValid;
  logic [ACC_W-1:0]        resData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  longint model [DEPTH];

  always #2.5 clk = ~clk;

  col_psum_adder #(
    .LANES(LANES), .PROD_W(PROD_W), .ACC_W(ACC_W), .DEPTH(DEPTH)
  ) u_col_psum_adder (
    .clk(clk), .rstN(rstN), .accReq(accReq), .clearFirst(clearFirst),
    .biasEn(biasEn), .biasIn(biasIn), .denseEn(denseEn), .laneMask(laneMask),
    .prodIn(prodIn), .rowAddr(rowAddr), .drainReq(drainReq), .reluEn(reluEn),
    .resValid(resValid), .resData(resData)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  // One accumulate; lanes l0..l3 map to lane 0..3
  task automatic doAcc(input int addr, input int l0, input int l1, input int l2, input int l3,
                       input bit dense, input logic [LANES-1:0] mask,
                       input bit fresh, input bit useBias, input longint bias);
    longint contrib;
    int lv [LANES];
    lv[0] = l0; lv[1] = l1; lv[2] = l2; lv[3] = l3;
    @(negedge clk);
    for (int i = 0; i < LANES; i++) prodIn[i*PROD_W +: PROD_W] = PROD_W'(lv[i]);
    rowAddr = ADDR_W'(addr); denseEn = dense; laneMask = mask;
    clearFirst = fresh; biasEn = useBias; biasIn = ACC_W'(bias); accReq = 1'b1;
    @(negedge clk);
    accReq = 1'b0; biasEn = 1'b0; clearFirst = 1'b0;
    contrib = useBias ? bias : 0;
    for (int i = 0; i < LANES; i++) if (dense || mask[i]) contrib += lv[i];
    model[addr] = sat((fresh ? 0 : model[addr]) + contrib);
  endtask

  // Drain one entry and compare against expectation
  task automatic doDrain(input int addr, input bit relu, input longint exp, input string tag);
    @(negedge clk);
    rowAddr = ADDR_W'(addr); reluEn = relu; drainReq = 1'b1;
    @(negedge clk);
    drainReq = 1'b0; reluEn = 1'b0;
    check(resValid === 1'b1, {tag, " valid"}, longint'(resValid), 1);
    check(longint'($signed(resData)) == exp, tag, longint'($signed(resData)), exp);
  endtask

  task automatic t_reset();
    check(resValid === 1'b0, "R1 resValid", longint'(resValid), 0);
    check(resData === '0, "R1 resData", longint'(resData), 0);
    for (int a = 0; a < DEPTH; a++) doDrain(a, 1'b0, 0, "R1 entry");
    @(negedge clk);
    check(resValid === 1'b0, "R7 idle valid", longint'(resValid), 0);
  endtask

  task automatic t_dense();
    doAcc(0, 10, 20, 30, 40, 1'b1, 4'b0000, 1'b1, 1'b0, 0);
    doDrain(0, 1'b0, 100, "R4 dense ignores mask");
    doAcc(0, 1, -2, 3, -4, 1'b1, 4'b1010, 1'b0, 1'b0, 0);
    doDrain(0, 1'b0, model[0], "R3 accumulate");
    doAcc(0, 5, 5, 5, 5, 1'b1, 4'b1111, 1'b1, 1'b0, 0);
    doDrain(0, 1'b0, 20, "R2 fresh load");
  endtask

  task automatic t_sparse();
    doAcc(1, 100, 200, 300, 400, 1'b0, 4'b0101, 1'b1, 1'b0, 0);
    doDrain(1, 1'b0, 400, "R5 sparse mask 0101");
    doAcc(1, 100, 200, 300, 400, 1'b0, 4'b1000, 1'b0, 1'b0, 0);
    doDrain(1, 1'b0, 800, "R5 sparse mask 1000");
    doAcc(1, 7, 7, 7, 7, 1'b0, 4'b0000, 1'b0, 1'b0, 0);
    doDrain(1, 1'b0, 800, "R5 empty mask");
  endtask

  task automatic t_bias();
    doAcc(2, 1, 1, 1, 1, 1'b1, 4'b0000, 1'b1, 1'b1, -1000);
    doDrain(2, 1'b0, -996, "R6 bias added");
    doAcc(2, 0, 0, 0, 0, 1'b1, 4'b0000, 1'b0, 1'b0, 0);
    doDrain(2, 1'b0, -996, "R6 bias ignored when off");
  endtask

  task automatic t_relu();
    doDrain(2, 1'b1, 0, "R8 relu negative");
    doDrain(2, 1'b0, -996, "R8 relu off");
    doDrain(1, 1'b1, 800, "R8 relu positive");
  endtask

  task automatic t_priority();
    @(negedge clk);
    prodIn = '0; prodIn[PROD_W-1:0] = PROD_W'(55);
    rowAddr = ADDR_W'(1); denseEn = 1'b1; clearFirst = 1'b0;
    accReq = 1'b1; drainReq = 1'b1;
    @(negedge clk);
    accReq = 1'b0; drainReq = 1'b0;
    check(longint'($signed(resData)) == 800, "R9 drain wins output", longint'($signed(resData)), 800);
    doDrain(1, 1'b0, 800, "R9 entry unchanged");
  endtask

  task automatic t_saturate();
    doAcc(3, 100, 0, 0, 0, 1'b1, 4'b0000, 1'b1, 1'b1, 64'sd2147483600);
    doDrain(3, 1'b0, MAXV, "R10 load sat high");
    doAcc(3, 1, 1, 1, 1, 1'b1, 4'b0000, 1'b0, 1'b0, 0);
    doDrain(3, 1'b0, MAXV, "R10 add sat high");
    doAcc(4, -100, -100, 0, 0, 1'b1, 4'b0000, 1'b1, 1'b1, -64'sd2147483600);
    doDrain(4, 1'b0, MINV, "R10 load sat low");
    doAcc(4, -32768, 0, 0, 0, 1'b1, 4'b0000, 1'b0, 1'b0, 0);
    doDrain(4, 1'b0, MINV, "R10 add sat low");
  endtask

  task automatic t_independent();
    for (int a = 0; a < DEPTH; a++) doAcc(a, a + 1, 0, 0, 0, 1'b1, 4'b0000, 1'b1, 1'b0, 0);
    doAcc(5, 1000, 0, 0, 0, 1'b1, 4'b0000, 1'b0, 1'b0, 0);
    for (int a = 0; a < DEPTH; a++) doDrain(a, 1'b0, model[a], "R11 entry isolation");
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_dense();
    t_sparse();
    t_bias();
    t_relu();
    t_priority();
    t_saturate();
    t_independent();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule